// File: doc/BRIEF.md
# Bus-Side Error Correcting Datapath

This block sits beside a processor's 32-bit memory bus and protects each stored word with seven check bits. On a write it latches the word from the bus and drives freshly computed check bits onto a separate check bus. On a read it latches the word and its stored check bits, forms a syndrome and raises one of two flags: a correctable-error flag for a single flipped bit and a fatal flag for any other nonzero syndrome. It can then place the repaired word in an output latch so that the word can be driven back onto the bus.

Each of the four data byte lanes has its own output enable, and the check bus has a fifth. Steering inputs choose what the check bus carries: generated check bits, the syndrome or a diagnostic byte. A diagnostic latch can also stand in for the stored check bits. Byte and halfword stores run as a five-state read-modify-write sequence: read, correct, merge the new lanes, then write back with regenerated check bits. The sequence gives up when the read is uncorrectable and reports that until the next sequence starts.

The "latches" are clocked: a latch takes its input at every rising edge where its enable is high and holds its value while the enable is low.

Top module: `ecc_bus_guard`

## Requirements
- R1: With `syn_sel`=0 and `diag_mode`=00, `cbus_out` equals the check bits of the data-in latch. Check bit j is the XOR of every data bit i whose column has bit j set. The column of data bit i is the i-th smallest (counting from 0) 7-bit value with exactly three ones.
- R2: The data-in, check-in and diagnostic latches load `dbus_in`, `cbus_in` and `cbus_in` respectively at a rising edge where their enable (`din_le`, `cin_le`, `diag_le`) is high. They hold while it is low. Results show one cycle after the edge.
- R3: With `syn_sel`=1 and `diag_mode`=00, `cbus_out` carries the syndrome, which is the generated check bits XOR the check source. A flipped data bit i gives its column as the syndrome, and a flipped check bit j gives 1<<j.
- R4: A syndrome equal to one column raises `err_fix` only. If `out_le` and `fix_en` are high at the next edge, the output latch (`dbus_out`) takes the word with data bit i inverted. A check-bit-only error leaves the data unchanged.
- R5: Any nonzero syndrome that matches no column raises `err_fatal` only, and no bit is inverted. Every double-bit error falls into this case.
- R6: With `fix_en`=0, `out_le` copies the data-in latch into the output latch unmodified, even when `err_fix` is high.
- R7: With `diag_mode`=01, the diagnostic latch replaces the check-in latch as the check source for syndrome and flags.
- R8: With `diag_mode`=10, `cbus_out` carries the diagnostic latch contents.
- R9: When idle, `dbus_oe` equals `lane_oe_req` (bit k enables bits 8k+7:8k) and `cbus_oe` equals `chk_oe_req`. After reset, both enables are 0, the output latch is 0 and no sequence is pending.
- R10: `rmw_start` at edge e0 latches `rmw_mask`. The bus word and check bits present at e1 are read. The corrected word enters the output latch at e2. At e3 each lane whose mask bit is set takes `dbus_in`. After e3, for one cycle, `rmw_done`=1, `dbus_oe`=1111, `cbus_oe`=1, `dbus_out` is the merged word and `cbus_out` is its check bits.
- R11: If the word read at e1 is fatal, the sequence returns to idle at e2 without a write-back. `rmw_abort` stays 1 until the next `rmw_start`.
- R12: While `rmw_busy` is high, the external latch enables, `lane_oe_req` and `chk_oe_req` are ignored. The outputs are undriven except in the write-back cycle.
- R13: `err_fix` and `err_fatal` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbus_in | input | 32 | Data bus as seen by the block |
| dbus_out | output | 32 | Output latch contents toward the data bus |
| dbus_oe | output | 4 | Per-lane data bus drive enables |
| cbus_in | input | 7 | Check bus as seen by the block |
| cbus_out | output | 7 | Value driven toward the check bus |
| cbus_oe | output | 1 | Check bus drive enable |
| din_le | input | 1 | Data-in latch enable |
| cin_le | input | 1 | Check-in latch enable |
| diag_le | input | 1 | Diagnostic latch enable |
| out_le | input | 1 | Output latch enable |
| lane_oe_req | input | 4 | Requested data lane enables |
| chk_oe_req | input | 1 | Requested check bus enable |
| syn_sel | input | 1 | Put syndrome on check bus |
| fix_en | input | 1 | Apply correction on output latch load |
| diag_mode | input | 2 | 00 normal, 01 diag latch as check source, 10 drive diag latch |
| rmw_start | input | 1 | Begin read-modify-write |
| rmw_mask | input | 4 | Lanes replaced by new data |
| rmw_busy | output | 1 | Sequence in progress |
| rmw_done | output | 1 | Write-back cycle |
| rmw_abort | output | 1 | Last sequence stopped on fatal read |
| err_fix | output | 1 | Correctable error |
| err_fatal | output | 1 | Uncorrectable error |

## Verification
A stale or wrongly loaded input latch appears on `cbus_out` one cycle after its edge, as check bits or a syndrome that do not match the bus word. A wrong correction mask shows in `dbus_out` one cycle after the `out_le` edge. A sequencer in the wrong state shows as missing or early lane enables or a wrong merged lane in the write-back cycle three edges after the start, or as a write-back after a fatal read. Sweeps over every single-bit position, many double-bit pairs and all sixteen lane masks catch each of these at the first affected cycle.

// File: rtl/edac_pkg.sv
package edac_pkg;
    parameter int DATA_W = 32;
    parameter int CHK_W  = 7;
    localparam int LANES = DATA_W / 8;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_READ = 3'd1,
        SQ_FIX  = 3'd2,
        SQ_MERGE = 3'd3,
        SQ_WBACK = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        DG_OFF    = 2'b00,
        DG_DETECT = 2'b01,
        DG_DRIVE  = 2'b10,
        DG_RSVD   = 2'b11
    } diag_e;

    // Column of data bit idx: idx-th smallest CHK_W-bit value of weight three
    function automatic logic [CHK_W-1:0] col_of(input int idx);
        logic [CHK_W-1:0] res;
        int n;
        res = '0;
        n = 0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            if ($countones(v[CHK_W-1:0]) == 3) begin
                if (n == idx) res = v[CHK_W-1:0];
                n++;
            end
        end
        return res;
    endfunction

    // Data bits that feed check bit j
    function automatic logic [DATA_W-1:0] row_of(input int j);
        logic [DATA_W-1:0] r;
        logic [CHK_W-1:0] c;
        r = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c = col_of(i);
            r[i] = c[j];
        end
        return r;
    endfunction
endpackage

// File: rtl/edac_encoder.sv
module edac_encoder
    import edac_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    output logic [CHK_W-1:0]  chk_o
);
    for (genvar j = 0; j < CHK_W; j++) begin : g_row
        localparam logic [DATA_W-1:0] ROW = row_of(j);
        assign chk_o[j] = ^(word_i & ROW);
    end
endmodule

// File: rtl/edac_decoder.sv
module edac_decoder
    import edac_pkg::*;
(
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] flip_o,
    output logic              fix_o,
    output logic              fatal_o
);
    logic [CHK_W-1:0] chk_hit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
        localparam logic [CHK_W-1:0] COL = col_of(i);
        assign flip_o[i] = (syn_i == COL);
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_ccol
        assign chk_hit[j] = (syn_i == CHK_W'(1 << j));
    end

    always_comb begin
        fix_o   = (|flip_o) || (|chk_hit);
        fatal_o = (syn_i != '0) && !fix_o;
    end
endmodule

// File: rtl/edac_rmw_seq.sv
module edac_rmw_seq
    import edac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LANES-1:0] mask_i,
    input  logic             fatal_i,
    output seq_st_e          st_o,
    output logic [LANES-1:0] mask_o,
    output logic             abort_o
);
    typedef struct packed {
        seq_st_e          st;
        logic [LANES-1:0] mask;
        logic             abort;
    } sq_t;

    sq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.st)
            SQ_IDLE: if (start_i) begin
                sq_d.st    = SQ_READ;
                sq_d.mask  = mask_i;
                sq_d.abort = 1'b0;
            end
            SQ_READ: sq_d.st = SQ_FIX;
            SQ_FIX: begin
                if (fatal_i) begin
                    sq_d.st    = SQ_IDLE;
                    sq_d.abort = 1'b1;
                end else begin
                    sq_d.st = SQ_MERGE;
                end
            end
            SQ_MERGE: sq_d.st = SQ_WBACK;
            SQ_WBACK: sq_d.st = SQ_IDLE;
            default:  sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, mask: '0, abort: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign st_o    = sq_q.st;
    assign mask_o  = sq_q.mask;
    assign abort_o = sq_q.abort;

    // R10
    wback_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == SQ_WBACK) |=> (sq_q.st == SQ_IDLE));

    // R11
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.st == SQ_IDLE && start_i) |=> !sq_q.abort);
endmodule

// File: rtl/ecc_bus_guard.sv
module ecc_bus_guard
    import edac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dbus_in,
    output logic [DATA_W-1:0] dbus_out,
    output logic [LANES-1:0]  dbus_oe,
    input  logic [CHK_W-1:0]  cbus_in,
    output logic [CHK_W-1:0]  cbus_out,
    output logic              cbus_oe,
    input  logic              din_le,
    input  logic              cin_le,
    input  logic              diag_le,
    input  logic              out_le,
    input  logic [LANES-1:0]  lane_oe_req,
    input  logic              chk_oe_req,
    input  logic              syn_sel,
    input  logic              fix_en,
    input  logic [1:0]        diag_mode,
    input  logic              rmw_start,
    input  logic [LANES-1:0]  rmw_mask,
    output logic              rmw_busy,
    output logic              rmw_done,
    output logic              rmw_abort,
    output logic              err_fix,
    output logic              err_fatal
);
    typedef struct packed {
        logic [DATA_W-1:0] din;
        logic [CHK_W-1:0]  cin;
        logic [CHK_W-1:0]  dg;
        logic [DATA_W-1:0] dout;
    } dp_t;

    dp_t dp_d, dp_q;

    seq_st_e           st;
    logic [LANES-1:0]  mask_q;
    logic              busy;
    logic [CHK_W-1:0]  gen_in, gen_out, chk_src, syn;
    logic [DATA_W-1:0] flip;
    logic              fix_hit, fatal_hit;
    diag_e             dmode;

    assign dmode = diag_e'(diag_mode);

    edac_encoder u_enc_in  (.word_i(dp_q.din),  .chk_o(gen_in));
    edac_encoder u_enc_out (.word_i(dp_q.dout), .chk_o(gen_out));

    edac_decoder u_dec (
        .syn_i   (syn),
        .flip_o  (flip),
        .fix_o   (fix_hit),
        .fatal_o (fatal_hit)
    );

    edac_rmw_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rmw_start),
        .mask_i  (rmw_mask),
        .fatal_i (fatal_hit),
        .st_o    (st),
        .mask_o  (mask_q),
        .abort_o (rmw_abort)
    );

    always_comb begin
        busy    = (st != SQ_IDLE);
        chk_src = (!busy && dmode == DG_DETECT) ? dp_q.dg : dp_q.cin;
        syn     = gen_in ^ chk_src;
    end

    always_comb begin
        dp_d = dp_q;
        if (busy ? (st == SQ_READ) : din_le) dp_d.din = dbus_in;
        if (busy ? (st == SQ_READ) : cin_le) dp_d.cin = cbus_in;
        if (!busy && diag_le)                dp_d.dg  = cbus_in;
        if (st == SQ_FIX) begin
            if (!fatal_hit) dp_d.dout = dp_q.din ^ flip;
        end else if (st == SQ_MERGE) begin
            for (int k = 0; k < LANES; k++) begin
                if (mask_q[k]) dp_d.dout[8*k +: 8] = dbus_in[8*k +: 8];
            end
        end else if (!busy && out_le) begin
            dp_d.dout = fix_en ? (dp_q.din ^ flip) : dp_q.din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    always_comb begin
        if (st == SQ_WBACK)          cbus_out = gen_out;
        else if (dmode == DG_DRIVE)  cbus_out = dp_q.dg;
        else if (syn_sel)            cbus_out = syn;
        else                         cbus_out = gen_in;

        if (st == SQ_WBACK) begin
            dbus_oe = '1;
            cbus_oe = 1'b1;
        end else if (busy) begin
            dbus_oe = '0;
            cbus_oe = 1'b0;
        end else begin
            dbus_oe = lane_oe_req;
            cbus_oe = chk_oe_req;
        end
    end

    assign dbus_out  = dp_q.dout;
    assign rmw_busy  = busy;
    assign rmw_done  = (st == SQ_WBACK);
    assign err_fix   = fix_hit;
    assign err_fatal = fatal_hit;

    // R13
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_fix, err_fatal}));

    // R2
    din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!din_le && !busy) |=> $stable(dp_q.din));

    // R10
    wback_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_done |-> (dbus_oe == '1 && cbus_oe && rmw_busy));

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rmw_abort) |-> (!rmw_busy && !rmw_done));

    // R12
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_busy && !rmw_done) |-> (dbus_oe == '0 && !cbus_oe));
endmodule

// File: tb/ecc_bus_guard_test.sv
module ecc_bus_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dbus_in = '0, dbus_out;
    logic [3:0]  dbus_oe;
    logic [6:0]  cbus_in = '0, cbus_out;
    logic        cbus_oe;
    logic        din_le = 0, cin_le = 0, diag_le = 0, out_le = 0;
    logic [3:0]  lane_oe_req = '0;
    logic        chk_oe_req = 0, syn_sel = 0, fix_en = 0;
    logic [1:0]  diag_mode = 2'b00;
    logic        rmw_start = 0;
    logic [3:0]  rmw_mask = '0;
    logic        rmw_busy, rmw_done, rmw_abort, err_fix, err_fatal;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ecc_bus_guard uut (.*);

    function automatic logic [6:0] col(input int idx);
        int n = 0;
        logic [6:0] r = '0;
        for (int v = 0; v < 128; v++) begin
            if ($countones(v[6:0]) == 3) begin
                if (n == idx) r = v[6:0];
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [6:0] enc(input logic [31:0] d);
        logic [6:0] c = '0;
        for (int i = 0; i < 32; i++) if (d[i]) c ^= col(i);
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [31:0] d, input logic [6:0] c);
        dbus_in = d; cbus_in = c; din_le = 1; cin_le = 1;
        tick();
        din_le = 0; cin_le = 0;
    endtask

    task automatic latch_out(input bit fx);
        fix_en = fx; out_le = 1;
        tick();
        out_le = 0; fix_en = 0;
    endtask

    task automatic run_rmw(input logic [3:0] m, input logic [31:0] mem_d, input logic [6:0] mem_c,
                           input logic [31:0] true_d, input logic [31:0] nw);
        logic [31:0] exp;
        rmw_start = 1; rmw_mask = m;
        tick();
        rmw_start = 0; rmw_mask = ~m;
        dbus_in = mem_d; cbus_in = mem_c;
        lane_oe_req = 4'hF; chk_oe_req = 1; din_le = 1;
        tick();
        // R12 controls ignored while busy
        chk(rmw_busy && dbus_oe == 4'h0 && !cbus_oe, "R12", {27'd0, rmw_busy, dbus_oe}, 32'h10);
        tick();
        dbus_in = nw;
        tick();
        exp = true_d;
        for (int k = 0; k < 4; k++) if (m[k]) exp[8*k +: 8] = nw[8*k +: 8];
        chk(dbus_out == exp, "R10 merged word", dbus_out, exp);
        chk(rmw_done && dbus_oe == 4'hF && cbus_oe, "R10 write-back enables", {27'd0, rmw_done, dbus_oe}, 32'h1F);
        chk(cbus_out == enc(exp), "R10 write-back check bits", {25'd0, cbus_out}, {25'd0, enc(exp)});
        lane_oe_req = 0; chk_oe_req = 0; din_le = 0;
        tick();
        chk(!rmw_busy && !rmw_done && !rmw_abort, "R10 back to idle", {29'd0, rmw_busy, rmw_done, rmw_abort}, 0);
    endtask

    initial begin
        #1;
        repeat (3) tick();
        // R9 reset state
        chk(dbus_oe == 0 && !cbus_oe && dbus_out == 0 && !rmw_busy && !rmw_abort, "R9 reset",
            {dbus_out[26:0], dbus_oe, cbus_oe}, 0);
        rst_n = 1;
        tick();

        // R1 encoding over walking ones and patterns
        for (int i = 0; i < 36; i++) begin
            logic [31:0] w;
            w = (i < 32) ? (32'h1 << i) : (i == 32 ? 32'hFFFF_FFFF : i == 33 ? 32'hA5C3_0F96 : i == 34 ? 32'h0 : 32'h1234_5678);
            load(w, 7'h0);
            chk(cbus_out == enc(w), "R1 encode", {25'd0, cbus_out}, {25'd0, enc(w)});
        end

        // R2 hold: bus changes with enables low
        load(32'hDEAD_BEEF, enc(32'hDEAD_BEEF));
        dbus_in = 32'h0; cbus_in = 7'h55;
        tick(); tick();
        syn_sel = 1;
        #1;
        chk(cbus_out == 0 && !err_fix && !err_fatal, "R2 latches hold", {25'd0, cbus_out}, 0);
        syn_sel = 0;

        // R3, R4: every single-bit position on two words
        for (int w = 0; w < 2; w++) begin
            logic [31:0] base;
            base = w ? 32'h8421_F00D : 32'h0;
            for (int p = 0; p < 39; p++) begin
                logic [31:0] d;
                logic [6:0] c, es;
                d = base; c = enc(base);
                if (p < 32) begin d[p] = ~d[p]; es = col(p); end
                else begin c[p-32] = ~c[p-32]; es = 7'(1 << (p-32)); end
                load(d, c);
                syn_sel = 1; #1;
                chk(cbus_out == es, "R3 syndrome", {25'd0, cbus_out}, {25'd0, es});
                syn_sel = 0;
                chk(err_fix && !err_fatal, "R4 single flag", {30'd0, err_fix, err_fatal}, 2);
                latch_out(1);
                chk(dbus_out == base, "R4 corrected", dbus_out, base);
            end
        end

        // R6 no correction when disabled
        load(32'h0000_0010, enc(32'h0));
        latch_out(0);
        chk(dbus_out == 32'h10, "R6 uncorrected", dbus_out, 32'h10);

        // R5 double errors
        for (int a = 0; a < 39; a += 3) begin
            for (int b = a + 1; b < 39; b += 5) begin
                logic [31:0] d;
                logic [6:0] c;
                d = 32'h5555_AAAA; c = enc(d);
                if (a < 32) d[a] = ~d[a]; else c[a-32] = ~c[a-32];
                if (b < 32) d[b] = ~d[b]; else c[b-32] = ~c[b-32];
                load(d, c);
                chk(err_fatal && !err_fix, "R5 double flag", {30'd0, err_fix, err_fatal}, 1);
                latch_out(1);
                chk(dbus_out == d, "R5 no bit flipped", dbus_out, d);
            end
        end

        // R7 diag latch as check source
        load(32'hCAFE_0001, 7'h00);
        cbus_in = enc(32'hCAFE_0001); diag_le = 1; tick(); diag_le = 0;
        diag_mode = 2'b01; #1;
        chk(!err_fix && !err_fatal, "R7 diag source clean", {30'd0, err_fix, err_fatal}, 0);
        cbus_in = enc(32'hCAFE_0001) ^ 7'h04; diag_le = 1; tick(); diag_le = 0;
        chk(err_fix, "R7 diag source single", {31'd0, err_fix}, 1);
        // R8 drive diag latch
        diag_mode = 2'b10; #1;
        chk(cbus_out == (enc(32'hCAFE_0001) ^ 7'h04), "R8 diag drive", {25'd0, cbus_out},
            {25'd0, enc(32'hCAFE_0001) ^ 7'h04});
        diag_mode = 2'b00;

        // R9 idle lane enables
        for (int m = 0; m < 16; m++) begin
            lane_oe_req = 4'(m); chk_oe_req = m[0]; #1;
            chk(dbus_oe == 4'(m) && cbus_oe == m[0], "R9 idle enables", {27'd0, dbus_oe, cbus_oe}, {27'd0, 4'(m), m[0]});
        end
        lane_oe_req = 0; chk_oe_req = 0;

        // R10 every mask, some with a single-bit memory error
        for (int m = 0; m < 16; m++) begin
            logic [31:0] t, md;
            t = 32'h1357_9BDF ^ (32'h0101_0101 * m);
            md = t;
            if (m[0]) md[m+7] = ~md[m+7];
            run_rmw(4'(m), md, enc(t), t, 32'hA0B1_C2D3 + m);
        end

        // R11 abort on fatal read
        rmw_start = 1; rmw_mask = 4'h1; tick(); rmw_start = 0;
        dbus_in = 32'h0000_0003; cbus_in = enc(32'h0);
        tick(); tick();
        chk(rmw_abort && !rmw_busy, "R11 abort", {30'd0, rmw_abort, rmw_busy}, 2);
        dbus_in = 32'hFFFF_FFFF;
        tick(); tick();
        chk(rmw_abort && !rmw_done && dbus_oe == 0 && !cbus_oe, "R11 abort held, no write",
            {26'd0, rmw_abort, rmw_done, dbus_oe}, 32'h20);
        run_rmw(4'h3, 32'h0F0F_0F0F, enc(32'h0F0F_0F0F), 32'h0F0F_0F0F, 32'h1111_2222);

        finished = 1;
    end

    initial begin
        for (int n = 0; n < 100000; n++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule